// File: doc/BRIEF.md
# Serial DAC command receiver

This block is the digital control core of an eight-channel, 8-bit voltage DAC. A host writes 12-bit commands over three serial wires: a shift clock, a data line and a load strobe. A fast system clock samples all serial pins through two-flop synchronizers and detects their edges synchronously. Each command carries a channel address, a gain-select bit and an 8-bit code.

Every channel has two stages of storage, a staging latch and an output latch. A load strobe writes the received word into the staging latch of the addressed channel. A separate active-low update input makes staged values visible on the outputs. While that input is low, every output latch follows its staging latch. When it is high, new values are held back until a later low pulse, which moves all channels at once. The outputs are one code and one gain bit per channel, ready to drive the analog converters.

Top module: `sdac_cmd_rx`

## Requirements
- R1: After reset, every code output is 0, every gain output is 0 (unity gain), and the shift register is cleared.
- R2: While the load input is high, each falling edge of the serial clock shifts one data bit in. The word is sent MSB first, and its bit layout is [11:9] channel address, [8] gain bit, [7:0] code.
- R3: Falling edges of the serial clock while the load input is low do not change the shift register.
- R4: A falling edge of the load input writes the word into the staging latch of the addressed channel only. Address value k (0 to 7) selects channel k, which drives code_o[8k+7:8k] and gain_o[k].
- R5: If the update input is low when the load input falls, the addressed channel's outputs take the new value in the same cycle as its staging latch.
- R6: While the update input is high, the outputs hold their values. A later low pulse on the update input copies every staged value to the outputs.
- R7: While the update input stays low, successive commands each appear on the outputs without any extra pulse.
- R8: A frame longer than 12 clocks uses only its last 12 bits. A 16-clock frame sent as two bytes has its 4 leading bits ignored.
- R9: The gain bit is stored per channel alongside the code: 0 selects unity gain, 1 selects double gain.
- R10: When the load falling edge and an update-input edge arrive at the same time, the synchronized update level in the write cycle decides whether the outputs take the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous power-on reset |
| ser_clk_i | input | 1 | Serial shift clock; bits are taken on its falling edge |
| ser_data_i | input | 1 | Serial data, MSB first |
| ser_load_i | input | 1 | High while shifting; its falling edge writes the staging latch |
| upd_ni | input | 1 | Active-low output update control |
| code_o | output | 64 | Eight 8-bit channel codes; channel k at [8k+7:8k] |
| gain_o | output | 8 | Per-channel gain select; 1 selects double gain |

## Verification
Two functions can fall in the same system cycle: the write into a staging latch and the level-driven transfer to the outputs. The bench provokes this by driving the load falling edge and an update-input edge at the same instant. Because both pins pass through synchronizers of equal depth, their edges meet in the same internal cycle. The outputs are then judged against a model that lets the update level seen in that cycle decide the result. Lowering both pins together must show the new value at once. Dropping the load strobe while raising the update input must leave the output at its old value until the next update pulse.

// File: rtl/sdac_pkg.sv
package sdac_pkg;
  localparam int DEF_N_CH   = 8;
  localparam int DEF_CODE_W = 8;
  localparam int SYN_CLK    = 0;
  localparam int SYN_DATA   = 1;
  localparam int SYN_LOAD   = 2;
  localparam int SYN_UPD    = 3;
  localparam int SYN_W      = 4;
endpackage

// File: rtl/sdac_sync.sv
module sdac_sync #(
  parameter int W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/sdac_shift.sv
module sdac_shift #(
  parameter int WORD_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_i,
  input  logic              sdata_i,
  input  logic              sload_i,
  output logic              sclk_fall_o,
  output logic              strobe_o,
  output logic [WORD_W-1:0] word_o
);
  logic              sclk_q, sload_q;
  logic [WORD_W-1:0] sr_q;

  assign sclk_fall_o = sclk_q & ~sclk_i;
  assign strobe_o    = sload_q & ~sload_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q  <= 1'b0;
      sload_q <= 1'b0;
      sr_q    <= '0;
    end else begin
      sclk_q  <= sclk_i;
      sload_q <= sload_i;
      // only the newest WORD_W bits survive a long frame
      if (sclk_fall_o && sload_i) sr_q <= {sr_q[WORD_W-2:0], sdata_i};
    end
  end

  assign word_o = sr_q;
endmodule

// File: rtl/sdac_bank.sv
module sdac_bank #(
  parameter int N_CH   = 8,
  parameter int CODE_W = 8,
  parameter int ADDR_W = 3
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     strobe_i,
  input  logic [ADDR_W-1:0]        addr_i,
  input  logic                     gain_i,
  input  logic [CODE_W-1:0]        code_i,
  input  logic                     xfer_i,
  output logic [N_CH-1:0]          wr_o,
  output logic [N_CH*CODE_W-1:0]   stage_code_o,
  output logic [N_CH-1:0]          stage_gain_o,
  output logic [N_CH*CODE_W-1:0]   code_o,
  output logic [N_CH-1:0]          gain_o
);
  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    localparam logic [ADDR_W-1:0] SEL = ADDR_W'(c);
    logic              wr;
    logic [CODE_W-1:0] st_code_q, out_code_q, st_code_d;
    logic              st_gain_q, out_gain_q, st_gain_d;

    assign wr        = strobe_i && (addr_i == SEL);
    assign st_code_d = wr ? code_i : st_code_q;
    assign st_gain_d = wr ? gain_i : st_gain_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        st_code_q  <= '0;
        st_gain_q  <= 1'b0;
        out_code_q <= '0;
        out_gain_q <= 1'b0;
      end else begin
        st_code_q <= st_code_d;
        st_gain_q <= st_gain_d;
        // level transfer: a write in this cycle passes straight through
        if (xfer_i) begin
          out_code_q <= st_code_d;
          out_gain_q <= st_gain_d;
        end
      end
    end

    assign wr_o[c]                        = wr;
    assign stage_code_o[c*CODE_W +: CODE_W] = st_code_q;
    assign stage_gain_o[c]                = st_gain_q;
    assign code_o[c*CODE_W +: CODE_W]       = out_code_q;
    assign gain_o[c]                      = out_gain_q;
  end
endmodule

// File: rtl/sdac_cmd_rx.sv
module sdac_cmd_rx
  import sdac_pkg::*;
#(
  parameter int N_CH   = DEF_N_CH,
  parameter int CODE_W = DEF_CODE_W
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   ser_clk_i,
  input  logic                   ser_data_i,
  input  logic                   ser_load_i,
  input  logic                   upd_ni,
  output logic [N_CH*CODE_W-1:0] code_o,
  output logic [N_CH-1:0]        gain_o
);
  localparam int ADDR_W = $clog2(N_CH);
  localparam int WORD_W = ADDR_W + 1 + CODE_W;

  logic [SYN_W-1:0]       pins, sync_q;
  logic                   sclk_fall, strobe;
  logic [WORD_W-1:0]      word;
  logic [N_CH-1:0]        wr_vec, stage_gain;
  logic [N_CH*CODE_W-1:0] stage_code;

  always_comb begin
    pins           = '0;
    pins[SYN_CLK]  = ser_clk_i;
    pins[SYN_DATA] = ser_data_i;
    pins[SYN_LOAD] = ser_load_i;
    pins[SYN_UPD]  = upd_ni;
  end

  sdac_sync #(.W(SYN_W)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pins),
    .q_o   (sync_q)
  );

  sdac_shift #(.WORD_W(WORD_W)) u_shift (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sclk_i     (sync_q[SYN_CLK]),
    .sdata_i    (sync_q[SYN_DATA]),
    .sload_i    (sync_q[SYN_LOAD]),
    .sclk_fall_o(sclk_fall),
    .strobe_o   (strobe),
    .word_o     (word)
  );

  sdac_bank #(.N_CH(N_CH), .CODE_W(CODE_W), .ADDR_W(ADDR_W)) u_bank (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .strobe_i    (strobe),
    .addr_i      (word[WORD_W-1 -: ADDR_W]),
    .gain_i      (word[CODE_W]),
    .code_i      (word[CODE_W-1:0]),
    .xfer_i      (~sync_q[SYN_UPD]),
    .wr_o        (wr_vec),
    .stage_code_o(stage_code),
    .stage_gain_o(stage_gain),
    .code_o      (code_o),
    .gain_o      (gain_o)
  );
endmodule

// File: rtl/sdac_cmd_rx_chk.sv
module sdac_cmd_rx_chk #(
  parameter int N_CH   = 8,
  parameter int CODE_W = 8,
  parameter int WORD_W = 12
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   upd_s,
  input logic                   load_s,
  input logic                   data_s,
  input logic                   sclk_fall,
  input logic [WORD_W-1:0]      shreg,
  input logic [N_CH-1:0]        wr_vec,
  input logic [N_CH*CODE_W-1:0] stage_code,
  input logic [N_CH-1:0]        stage_gain,
  input logic [N_CH*CODE_W-1:0] code_o,
  input logic [N_CH-1:0]        gain_o
);
  a_r2_shift_in: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sclk_fall && load_s |=> shreg[0] == $past(data_s));

  a_r3_no_shift: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_s |=> $stable(shreg));

  a_r4_one_target: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(wr_vec));

  a_r6_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_s |=> $stable(code_o) && $stable(gain_o));

  a_r7_follow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_s |=> code_o == stage_code && gain_o == stage_gain);
endmodule

bind sdac_cmd_rx sdac_cmd_rx_chk #(
  .N_CH(N_CH), .CODE_W(CODE_W), .WORD_W(WORD_W)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .upd_s     (sync_q[3]),
  .load_s    (sync_q[2]),
  .data_s    (sync_q[1]),
  .sclk_fall (sclk_fall),
  .shreg     (word),
  .wr_vec    (wr_vec),
  .stage_code(stage_code),
  .stage_gain(stage_gain),
  .code_o    (code_o),
  .gain_o    (gain_o)
);

// File: tb/sdac_cmd_rx_test.sv
module sdac_cmd_rx_test;
  localparam int CLK_P = 10;
  localparam int NCH   = 8;
  localparam int HOLD  = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sclk = 1'b0, sdata = 1'b0, sload = 1'b1, upd_n = 1'b1;
  logic [NCH*8-1:0] code;
  logic [NCH-1:0]   gain;

  int checks = 0, errors = 0;
  logic [7:0] st_c [NCH], out_c [NCH];
  logic       st_g [NCH], out_g [NCH];

  always #(CLK_P/2) clk = ~clk;

  sdac_cmd_rx uut (
    .clk_i(clk), .rst_ni(rst_n), .ser_clk_i(sclk), .ser_data_i(sdata),
    .ser_load_i(sload), .upd_ni(upd_n), .code_o(code), .gain_o(gain)
  );

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic follow_if_low();
    if (!upd_n) for (int c = 0; c < NCH; c++) begin out_c[c] = st_c[c]; out_g[c] = st_g[c]; end
  endtask

  task automatic check_all(input string tag);
    wait_cyc(HOLD);
    for (int c = 0; c < NCH; c++) begin
      checks++;
      if (code[c*8 +: 8] !== out_c[c]) begin
        errors++;
        $display("FAIL %s ch%0d code actual %h expected %h", tag, c, code[c*8 +: 8], out_c[c]);
      end
      checks++;
      if (gain[c] !== out_g[c]) begin
        errors++;
        $display("FAIL %s ch%0d gain actual %b expected %b", tag, c, gain[c], out_g[c]);
      end
    end
  endtask

  task automatic ser_bit(input logic b);
    sdata = b; sclk = 1'b1; wait_cyc(HOLD);
    sclk = 1'b0; wait_cyc(HOLD);
  endtask

  task automatic shift_bits(input logic [15:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) ser_bit(v[i]);
  endtask

  // LOAD pulse; upd_level is driven on the same instant LOAD falls
  task automatic pulse_load(input logic upd_level, input logic [11:0] w);
    sload = 1'b0; upd_n = upd_level;
    st_c[w[11:9]] = w[7:0]; st_g[w[11:9]] = w[8];
    follow_if_low();
    wait_cyc(HOLD);
    sload = 1'b1; wait_cyc(HOLD);
  endtask

  task automatic send_cmd(input logic [2:0] a, input logic g, input logic [7:0] d);
    shift_bits({4'h0, a, g, d}, 12);
    pulse_load(upd_n, {a, g, d});
  endtask

  task automatic pulse_upd();
    upd_n = 1'b0; follow_if_low(); wait_cyc(HOLD);
    upd_n = 1'b1; wait_cyc(HOLD);
  endtask

  initial begin
    #(CLK_P * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int c = 0; c < NCH; c++) begin st_c[c] = 0; out_c[c] = 0; st_g[c] = 0; out_g[c] = 0; end
    wait_cyc(3);
    rst_n = 1'b1;
    // R1: reset state
    check_all("R1");

    // R2 R4 R5 R9: address sweep with update input low
    upd_n = 1'b0; wait_cyc(HOLD);
    for (int c = 0; c < NCH; c++) begin
      send_cmd(3'(c), c[0], 8'(c * 37 + 5));
      check_all("R4_R5_R9");
    end

    // R6: staged while update high, then one pulse moves all
    upd_n = 1'b1; wait_cyc(HOLD);
    for (int c = 0; c < NCH; c++) begin
      send_cmd(3'(c), ~c[1], ~8'(c * 29));
      check_all("R6_hold");
    end
    pulse_upd();
    check_all("R6_copy");

    // R7: update held low, back-to-back commands
    upd_n = 1'b0; wait_cyc(HOLD);
    send_cmd(3'd1, 1'b1, 8'hC3); check_all("R7");
    send_cmd(3'd1, 1'b0, 8'h3C); check_all("R7");
    send_cmd(3'd7, 1'b1, 8'hFF); check_all("R7_R9");
    send_cmd(3'd0, 1'b0, 8'h00); check_all("R7");

    // R8: 16-clock frame as two bytes, 4 leading bits ignored
    shift_bits({4'hF, 3'd4, 1'b1, 8'hA5}, 16);
    pulse_load(1'b0, {3'd4, 1'b1, 8'hA5});
    check_all("R8");
    shift_bits({4'hA, 3'd2, 1'b0, 8'h5A}, 16);
    pulse_load(1'b0, {3'd2, 1'b0, 8'h5A});
    check_all("R8");

    // R3: clocks with LOAD low must not reach the shift register
    sload = 1'b0; wait_cyc(HOLD);
    for (int i = 0; i < 4; i++) ser_bit(1'b1);
    sload = 1'b1; wait_cyc(HOLD);
    pulse_load(1'b0, {3'd2, 1'b0, 8'h5A});
    check_all("R3");

    // R10: LOAD fall together with update falling -> immediate
    upd_n = 1'b1; wait_cyc(HOLD);
    shift_bits({4'h0, 3'd6, 1'b1, 8'h81}, 12);
    pulse_load(1'b0, {3'd6, 1'b1, 8'h81});
    check_all("R10_fall");
    // R10: LOAD fall together with update rising -> held
    shift_bits({4'h0, 3'd5, 1'b0, 8'h77}, 12);
    pulse_load(1'b1, {3'd5, 1'b0, 8'h77});
    check_all("R10_rise");
    pulse_upd();
    check_all("R10_copy");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule